// File: doc/BRIEF.md
# Page Write Buffer and Word Address Counter

This block sits behind a serial protocol engine in a byte-addressed nonvolatile memory model. It keeps the word address counter and a one-page staging buffer, and owns the storage array, which is an internal register array. The engine loads a word address, then either pushes write bytes or pulls read bytes. Written bytes collect in the staging buffer, not in the array. When the engine reports the STOP that ends a write, the block opens a timed busy window. During that window it copies the staged bytes into the array, and it ignores every engine request.

The address counter follows two increment rules. A write byte advances only the in-page offset, so the address wraps back to the start of the same page. A read byte advances the full address, so reading runs across page boundaries and wraps from the top of the array to zero. The counter holds its value between transactions, which gives a current-address read with no new load. A write-protect input stops any commit. The default array is 2048 bytes (ADDR_W = 11). Setting ADDR_W to 16 gives the full 65,536-byte organisation of 512 pages of 128 bytes. WR_CYCLES scales the nominal 5 ms write cycle to clock cycles.

Top module: `eeprom_page_core`

## Requirements
- R1: After reset, busy_o, rd_valid_o and rd_data_o are 0, and the word address counter is 0. A write byte sent with no address load therefore lands at address 0.
- R2: Each accepted write byte goes to the slot given by counter bits [PAGE_W-1:0] and then increments only those bits. The upper bits hold, so the byte after offset PAGE_BYTES-1 goes to offset 0 of the same page.
- R3: When more than PAGE_BYTES bytes are written in one transaction, later bytes overwrite the earlier bytes staged at the same offset, and the last value written is committed.
- R4: A commit changes only the offsets that received a byte in the transaction. Other bytes of the page keep their old contents. All staging flags are clear once busy_o falls.
- R5: A stop_i pulse with at least one staged byte and wp_i low sets busy_o from the next cycle. busy_o stays high for exactly WR_CYCLES cycles. The array shows the new bytes after busy_o falls.
- R6: Each accepted read returns the byte at the counter on rd_data_o, with rd_valid_o high in the cycle after the request. It then increments the full counter, wrapping from the last address to 0.
- R7: The counter keeps the last accessed address plus one across transactions. A read with no prior load returns the byte that follows the last one accessed.
- R8: When wp_i is high at stop_i, the block starts no busy window, the array is unchanged, and the staged bytes are discarded.
- R9: An address load followed by stop_i with no staged byte (a dummy write) sets only the counter and starts no busy window.
- R10: While busy_o is high, addr_load_i, wr_byte_i, rd_byte_i and stop_i are ignored. The counter and staging buffer keep their state and rd_valid_o stays low. Request priority otherwise is load, then write, then read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wp_i | input | 1 | Write protect; high blocks every commit |
| addr_load_i | input | 1 | Load addr_i into the word address counter |
| addr_i | input | ADDR_W | Word address from the protocol engine |
| wr_byte_i | input | 1 | Stage one write byte at the counter |
| wr_data_i | input | DATA_W | Write byte |
| stop_i | input | 1 | STOP seen by the engine; starts a commit when bytes are staged |
| rd_byte_i | input | 1 | Request the byte at the counter |
| rd_data_o | output | DATA_W | Read byte |
| rd_valid_o | output | 1 | rd_data_o holds a fresh byte |
| busy_o | output | 1 | Timed write cycle in progress |

## Verification
The hardest case to reach from the ports is a request arriving inside the busy window. The bench must show that nothing changed, yet it can only look after the window closes. To do this, it stages a full page, so that the counter wraps back to the page start. During busy_o it then issues an address load, a write byte and a read. After the window it sends a STOP, which must not reopen busy, proving no byte was staged. It then performs a current-address read, which must return the committed page-start byte and not the byte at the address that was ignored. Array-end read wrap is reached by committing the last page and page 0 in separate transactions before a read that crosses the boundary.

// File: rtl/epc_pkg.sv
package epc_pkg;

   typedef enum logic {
      CM_IDLE = 1'b0,
      CM_BUSY = 1'b1
   } commit_state_e;

endpackage

// File: rtl/epc_addr_ctr.sv
module epc_addr_ctr #(
   parameter int ADDR_W = 11,
   parameter int PAGE_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy_i,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] load_addr_i,
   input  logic              wr_step_i,
   input  logic              rd_step_i,
   output logic [ADDR_W-1:0] addr_o
);

   localparam int ROW_W = ADDR_W - PAGE_W;

   logic [ADDR_W-1:0] addr_q;
   logic [PAGE_W-1:0] offs_next;

   assign offs_next = addr_q[PAGE_W-1:0] + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (!busy_i) begin
         if (load_i) begin
            addr_q <= load_addr_i;
         end else if (wr_step_i) begin
            addr_q <= {addr_q[ADDR_W-1:PAGE_W], offs_next};
         end else if (rd_step_i) begin
            addr_q <= addr_q + 1'b1;
         end
      end
   end

   assign addr_o = addr_q;

   AST_PAGE_ROW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_i && wr_step_i && !load_i) |=>
         (addr_o[ADDR_W-1:PAGE_W] == $past(addr_o[ADDR_W-1:PAGE_W]))); // R2

   AST_READ_ARRAY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_i && rd_step_i && !load_i && !wr_step_i && (&addr_o)) |=>
         (addr_o == '0)); // R6

   AST_COUNTER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |=> $stable(addr_o)); // R10

   logic [ROW_W-1:0] unused_row;
   assign unused_row = addr_q[ADDR_W-1:PAGE_W];

endmodule

// File: rtl/epc_page_buf.sv
module epc_page_buf #(
   parameter int PAGE_W = 7,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [PAGE_W-1:0] wr_slot_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              clear_i,
   input  logic [PAGE_W-1:0] rd_slot_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              rd_flag_o,
   output logic              any_o
);

   localparam int PAGE_BYTES = 1 << PAGE_W;

   logic [DATA_W-1:0]     slot_q [PAGE_BYTES];
   logic [PAGE_BYTES-1:0] flag_q;

   always_ff @(posedge clk) begin
      if (wr_en_i) begin
         slot_q[wr_slot_i] <= wr_data_i;
      end
   end

   for (genvar s = 0; s < PAGE_BYTES; s++) begin : g_flag
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            flag_q[s] <= 1'b0;
         end else if (clear_i) begin
            flag_q[s] <= 1'b0;
         end else if (wr_en_i && (wr_slot_i == PAGE_W'(s))) begin
            flag_q[s] <= 1'b1;
         end
      end
   end

   assign rd_data_o = slot_q[rd_slot_i];
   assign rd_flag_o = flag_q[rd_slot_i];
   assign any_o     = |flag_q;

   AST_SLOT_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && !clear_i) |=> flag_q[$past(wr_slot_i)]); // R4

   AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> !any_o); // R4

endmodule

// File: rtl/epc_commit_timer.sv
module epc_commit_timer
   import epc_pkg::*;
#(
   parameter int PAGE_W    = 7,
   parameter int WR_CYCLES = 200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   output logic              busy_o,
   output logic              idx_valid_o,
   output logic [PAGE_W-1:0] idx_o,
   output logic              done_o
);

   localparam int PAGE_BYTES = 1 << PAGE_W;
   localparam int CNT_W      = $clog2(WR_CYCLES + 1);
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WR_CYCLES - 1);
   localparam logic [CNT_W-1:0] PAGE_CNT = CNT_W'(PAGE_BYTES);

   commit_state_e    state_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= CM_IDLE;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            CM_IDLE: begin
               if (start_i) begin
                  state_q <= CM_BUSY;
                  cnt_q   <= '0;
               end
            end
            CM_BUSY: begin
               if (cnt_q == LAST_CNT) begin
                  state_q <= CM_IDLE;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: state_q <= CM_IDLE;
         endcase
      end
   end

   assign busy_o      = (state_q == CM_BUSY);
   assign idx_valid_o = busy_o && (cnt_q < PAGE_CNT);
   assign idx_o       = cnt_q[PAGE_W-1:0];
   assign done_o      = busy_o && (cnt_q == LAST_CNT);

   AST_WINDOW_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_o); // R5

   AST_WINDOW_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> (busy_o && cnt_q == '0)); // R5

endmodule

// File: rtl/eeprom_page_core.sv
module eeprom_page_core #(
   parameter int ADDR_W    = 11,
   parameter int PAGE_W    = 7,
   parameter int DATA_W    = 8,
   parameter int WR_CYCLES = 200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wp_i,
   input  logic              addr_load_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_byte_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              stop_i,
   input  logic              rd_byte_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              rd_valid_o,
   output logic              busy_o
);

   localparam int DEPTH      = 1 << ADDR_W;
   localparam int PAGE_BYTES = 1 << PAGE_W;
   localparam int ROW_W      = ADDR_W - PAGE_W;

   if (ADDR_W <= PAGE_W) begin : g_bad_geometry
      $error("ADDR_W must exceed PAGE_W");
   end
   if (WR_CYCLES < PAGE_BYTES) begin : g_bad_window
      $error("WR_CYCLES must cover one copy cycle per page slot");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be positive");
   end

   logic [ADDR_W-1:0] cur_addr;
   logic              wr_en, rd_en, start_commit, discard, clear_flags;
   logic              any_pend, buf_flag, idx_valid, commit_done;
   logic [PAGE_W-1:0] commit_idx;
   logic [DATA_W-1:0] buf_byte;
   logic [ROW_W-1:0]  commit_row_q;
   logic [DATA_W-1:0] mem_q [DEPTH];
   logic [DATA_W-1:0] rd_data_q;
   logic              rd_valid_q;

   assign wr_en        = wr_byte_i && !busy_o && !addr_load_i;
   assign rd_en        = rd_byte_i && !busy_o && !addr_load_i && !wr_byte_i;
   assign start_commit = stop_i && !busy_o && any_pend && !wp_i;
   assign discard      = stop_i && !busy_o && wp_i;
   assign clear_flags  = commit_done || discard;

   epc_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
      .clk         (clk),
      .rst_n       (rst_n),
      .busy_i      (busy_o),
      .load_i      (addr_load_i),
      .load_addr_i (addr_i),
      .wr_step_i   (wr_byte_i),
      .rd_step_i   (rd_byte_i),
      .addr_o      (cur_addr)
   );

   epc_page_buf #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en),
      .wr_slot_i (cur_addr[PAGE_W-1:0]),
      .wr_data_i (wr_data_i),
      .clear_i   (clear_flags),
      .rd_slot_i (commit_idx),
      .rd_data_o (buf_byte),
      .rd_flag_o (buf_flag),
      .any_o     (any_pend)
   );

   epc_commit_timer #(.PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_tmr (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_commit),
      .busy_o      (busy_o),
      .idx_valid_o (idx_valid),
      .idx_o       (commit_idx),
      .done_o      (commit_done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         commit_row_q <= '0;
      end else if (start_commit) begin
         commit_row_q <= cur_addr[ADDR_W-1:PAGE_W];
      end
   end

   always_ff @(posedge clk) begin
      if (idx_valid && buf_flag && !wp_i) begin
         mem_q[{commit_row_q, commit_idx}] <= buf_byte;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data_q  <= '0;
         rd_valid_q <= 1'b0;
      end else begin
         rd_valid_q <= rd_en;
         if (rd_en) begin
            rd_data_q <= mem_q[cur_addr];
         end
      end
   end

   assign rd_data_o  = rd_data_q;
   assign rd_valid_o = rd_valid_q;

   AST_STOP_OPENS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_i && !busy_o && any_pend && !wp_i) |=> busy_o); // R5

   AST_DUMMY_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_i && !busy_o && !any_pend) |=> !busy_o); // R9

   AST_WP_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(!wp_i)); // R8

   AST_NO_READ_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> !rd_valid_o); // R10

   AST_FLAGS_EMPTY_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> !any_pend); // R4

endmodule

// File: tb/tb_eeprom_page_core.sv
module tb_eeprom_page_core;

   localparam int ADDR_W    = 11;
   localparam int PAGE_W    = 7;
   localparam int DATA_W    = 8;
   localparam int WR_CYCLES = 200;
   localparam int DEPTH     = 1 << ADDR_W;
   localparam int PAGE_B    = 1 << PAGE_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wp_i = 1'b0;
   logic              addr_load_i = 1'b0;
   logic [ADDR_W-1:0] addr_i = '0;
   logic              wr_byte_i = 1'b0;
   logic [DATA_W-1:0] wr_data_i = '0;
   logic              stop_i = 1'b0;
   logic              rd_byte_i = 1'b0;
   logic [DATA_W-1:0] rd_data_o;
   logic              rd_valid_o;
   logic              busy_o;

   always #4 clk = ~clk;

   eeprom_page_core #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W),
                      .WR_CYCLES(WR_CYCLES)) dut (
      .clk(clk), .rst_n(rst_n), .wp_i(wp_i), .addr_load_i(addr_load_i),
      .addr_i(addr_i), .wr_byte_i(wr_byte_i), .wr_data_i(wr_data_i),
      .stop_i(stop_i), .rd_byte_i(rd_byte_i), .rd_data_o(rd_data_o),
      .rd_valid_o(rd_valid_o), .busy_o(busy_o)
   );

   int nchk = 0;
   int nfail = 0;
   bit done_flag = 1'b0;

   logic [DATA_W-1:0] model [DEPTH];
   logic [DATA_W-1:0] pend_d [PAGE_B];
   bit   [PAGE_B-1:0] pend_v = '0;
   logic [ADDR_W-1:0] am = '0;

   logic [DATA_W-1:0] exp_q [$];
   string             tag_q [$];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   endtask

   // monitor: pops expected read bytes as they appear
   always @(negedge clk) begin
      if (rst_n && rd_valid_o) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R10 unexpected read", int'(rd_data_o), 0);
         end else begin
            automatic logic [DATA_W-1:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            chk(rd_data_o === e, t, int'(rd_data_o), int'(e));
         end
      end
   end

   task automatic ld(input logic [ADDR_W-1:0] a);
      @(negedge clk); addr_load_i = 1'b1; addr_i = a; am = a;
      @(negedge clk); addr_load_i = 1'b0;
   endtask

   task automatic wr(input logic [DATA_W-1:0] b);
      @(negedge clk); wr_byte_i = 1'b1; wr_data_i = b;
      pend_d[am[PAGE_W-1:0]] = b;
      pend_v[am[PAGE_W-1:0]] = 1'b1;
      am = {am[ADDR_W-1:PAGE_W], am[PAGE_W-1:0] + 1'b1};
      @(negedge clk); wr_byte_i = 1'b0;
   endtask

   task automatic rd(input string tag);
      @(negedge clk); rd_byte_i = 1'b1;
      exp_q.push_back(model[am]);
      tag_q.push_back(tag);
      am = am + 1'b1;
      @(negedge clk); rd_byte_i = 1'b0;
   endtask

   task automatic stop_pulse();
      @(negedge clk); stop_i = 1'b1;
      @(negedge clk); stop_i = 1'b0;
      if (!wp_i) begin
         for (int s = 0; s < PAGE_B; s++)
            if (pend_v[s]) model[{am[ADDR_W-1:PAGE_W], PAGE_W'(s)}] = pend_d[s];
      end
      pend_v = '0;
   endtask

   task automatic measure_busy(input string tag);
      int n = 0;
      while (busy_o && n < 100000) begin
         n++;
         @(negedge clk);
      end
      chk(n == WR_CYCLES, tag, n, WR_CYCLES);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(busy_o == 1'b0, "R1 busy after reset", int'(busy_o), 0);
      chk(rd_valid_o == 1'b0, "R1 rd_valid after reset", int'(rd_valid_o), 0);
      chk(rd_data_o == '0, "R1 rd_data after reset", int'(rd_data_o), 0);
      rst_n = 1'b1;

      // R1: counter is 0 after reset: unloaded write goes to address 0
      wr(8'h3C);
      stop_pulse();
      measure_busy("R5 busy length single byte");
      ld(11'h000); rd("R1 byte at address 0");

      // R4 prefill page 2, then partial write
      ld(11'h100);
      for (int i = 0; i < PAGE_B; i++) wr(8'(i) ^ 8'h5A);
      stop_pulse();
      chk(busy_o == 1'b1, "R5 busy next cycle after stop", int'(busy_o), 1);
      measure_busy("R5 busy length full page");
      ld(11'h105);
      wr(8'hA0); wr(8'hA1); wr(8'hA2);
      stop_pulse();
      measure_busy("R5 busy length partial");
      ld(11'h100);
      for (int i = 0; i < 12; i++) rd("R4 partial page contents");

      // R2 in-page wrap on write
      ld(11'h17E);
      wr(8'hC0); wr(8'hC1); wr(8'hC2); wr(8'hC3);
      stop_pulse();
      measure_busy("R5 busy length wrap write");
      rd("R7 current read after write uses 0x102");
      ld(11'h17E); rd("R2 offset 7E"); rd("R2 offset 7F");
      ld(11'h100); rd("R2 wrapped to 100"); rd("R2 wrapped to 101");

      // R3 overflow: 130 bytes into page 4
      ld(11'h205);
      for (int i = 0; i < PAGE_B + 2; i++) wr(8'(i + 8'h10));
      stop_pulse();
      measure_busy("R5 busy length overflow");
      ld(11'h200);
      for (int i = 0; i < 10; i++) rd("R3 overflow overwrite");

      // R6 array-end wrap on read
      ld(11'h7FE); wr(8'hE1); wr(8'hE2); stop_pulse(); measure_busy("R5 last page");
      ld(11'h000); wr(8'hF1); wr(8'hF2); stop_pulse(); measure_busy("R5 first page");
      ld(11'h7FE);
      rd("R6 7FE"); rd("R6 7FF"); rd("R6 wrap to 000"); rd("R6 001");

      // R8 write protect
      wp_i = 1'b1;
      ld(11'h100); wr(8'h99); wr(8'h98);
      stop_pulse();
      chk(busy_o == 1'b0, "R8 no busy under protect", int'(busy_o), 0);
      wp_i = 1'b0;
      @(negedge clk); stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
      chk(busy_o == 1'b0, "R8 staged bytes discarded", int'(busy_o), 0);
      ld(11'h100); rd("R8 array unchanged"); rd("R8 array unchanged");

      // R9 dummy write
      ld(11'h7FF);
      stop_pulse();
      chk(busy_o == 1'b0, "R9 dummy write no busy", int'(busy_o), 0);
      rd("R9 current read at loaded address"); rd("R6 wrap after dummy");

      // R10 requests ignored while busy
      ld(11'h300);
      for (int i = 0; i < PAGE_B; i++) wr(8'(i + 8'h40));
      stop_pulse();
      chk(busy_o == 1'b1, "R10 window open", int'(busy_o), 1);
      @(negedge clk); addr_load_i = 1'b1; addr_i = 11'h000;
      @(negedge clk); addr_load_i = 1'b0; wr_byte_i = 1'b1; wr_data_i = 8'hEE;
      @(negedge clk); wr_byte_i = 1'b0; rd_byte_i = 1'b1;
      @(negedge clk); rd_byte_i = 1'b0;
      @(negedge clk);
      chk(rd_valid_o == 1'b0, "R10 no read during busy", int'(rd_valid_o), 0);
      while (busy_o) @(negedge clk);
      @(negedge clk); stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
      chk(busy_o == 1'b0, "R10 no byte staged during busy", int'(busy_o), 0);
      rd("R10 counter kept page start 300");
      rd("R7 sequential 301");

      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R6 all reads returned", exp_q.size(), 0);
      finish_run();
   end

endmodule